// File: doc/BRIEF.md
# MSI Interrupt Request Controller

This block takes message-signalled interrupt requests from application logic on behalf of one of two physical functions and settles each one as a message write, a recorded pending vector or an abort. Each function supplies its own configuration as plain inputs: a 64-bit message address, 16-bit message data, an enable bit, a 3-bit vector-count code, a 32-bit per-vector mask. The block keeps a 32-bit pending register for each function.

A request is screened against the selected function's settings. A valid, unmasked request produces a message descriptor on a valid/ready port. It carries the address, the data with the vector number merged into its low bits, and the traffic class. A masked vector sets its pending bit instead. Anything else is refused. Every request ends with a one-cycle acknowledge and a status code. A separate write port lets the application set or clear single pending bits, which cancels a held interrupt.

Top module: `msi_req_ctrl`

## Requirements
- R1: While reset is applied and just after it, acknowledge, descriptor valid and the protocol-error flag are low, and all pending bits are 0.
- R2: Each accepted request is answered by an acknowledge lasting exactly one cycle, with status 2'b00 = sent, 2'b01 = held as pending, 2'b10 = aborted; 2'b11 is never produced.
- R3: A request whose function number is neither 0 nor 1, whose function enable bit is clear, or whose vector number is not below the enabled vector count is acknowledged with status 2'b10, with no descriptor and no pending-bit change.
- R4: The vector-count code of a function maps 3'b000→1, 3'b001→2, 3'b010→4, 3'b011→8, 3'b100→16, 3'b101→32, and 3'b110 or 3'b111→1 vector.
- R5: A sent descriptor carries the selected function's address and the request's traffic class. Its data is the function's data word with its low log2(count) bits replaced by the same low bits of the vector number.
- R6: If the function's mask bit at position fn*32+vec is set, the pending bit at position fn*32+vec of the pending output is set, no descriptor is raised, and the status is 2'b01.
- R7: A descriptor stays valid with stable address, data and class until ready is high. The acknowledge with status 2'b00 appears in the cycle after the handshake, and valid has dropped by then.
- R8: After an acknowledge, no new request is taken while the request input stays high. It must be low for at least one cycle first.
- R9: With the write enable high and no request, the pending bit at position fn*32+vec takes the 1-bit write data. A function number other than 0 or 1 changes nothing.
- R10: A pending write in the same cycle as a raised request is ignored, and a sticky protocol-error output goes high and stays high until reset.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Interrupt request |
| req_fn_i | input | 8 | Function number (request and pending write) |
| req_vec_i | input | 5 | Vector number (request and pending write) |
| req_tc_i | input | 3 | Traffic class of the request |
| ack_o | output | 1 | One-cycle acknowledge |
| status_o | output | 2 | Outcome code, valid with ack_o |
| pbw_en_i | input | 1 | Pending-bit write enable |
| pbw_data_i | input | 1 | Pending-bit write value |
| cfg_addr_i | input | 128 | Message address per function (function f at bits f*64) |
| cfg_data_i | input | 32 | Message data per function (function f at bits f*16) |
| cfg_en_i | input | 2 | Interrupt enable per function |
| cfg_mme_i | input | 6 | Vector-count code per function (function f at bits f*3) |
| cfg_mask_i | input | 64 | Per-vector mask, bit fn*32+vec |
| pend_o | output | 64 | Pending bits, bit fn*32+vec |
| msg_valid_o | output | 1 | Descriptor valid |
| msg_ready_i | input | 1 | Descriptor accepted |
| msg_addr_o | output | 64 | Descriptor address |
| msg_data_o | output | 16 | Descriptor data |
| msg_tc_o | output | 3 | Descriptor traffic class |
| proto_err_o | output | 1 | Sticky protocol-error flag |

## Verification
The request path and the pending-bit write port share the function and vector inputs, and the two can be driven in the same cycle. The bench provokes this by raising a request and a write of 1 in one cycle, aimed at a function with interrupts disabled. The request is then refused without touching the pending register. The write is judged ignored if the targeted pending bit is still 0 after the acknowledge. The clash is judged detected if the error flag has risen and stays up through later traffic.

// File: rtl/msi_req_pkg.sv
package msi_req_pkg;

  typedef enum logic [1:0] {
    STS_SENT  = 2'b00,
    STS_HELD  = 2'b01,
    STS_ABORT = 2'b10,
    STS_RSVD  = 2'b11
  } msi_sts_e;

  typedef enum logic [1:0] {
    FSM_IDLE = 2'b00,
    FSM_SEND = 2'b01,
    FSM_ACK  = 2'b10,
    FSM_HOLD = 2'b11
  } msi_fsm_e;

endpackage

// File: rtl/msi_rst_sync.sv
module msi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/msi_cfg_select.sv
module msi_cfg_select #(
  parameter int NUM_FN = 2,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 16,
  parameter int NVEC   = 32,
  parameter int FN_W   = 8,
  parameter int MME_W  = 3,
  localparam int VEC_W = $clog2(NVEC)
) (
  input  logic [FN_W-1:0]          fn_i,
  input  logic [VEC_W-1:0]         vec_i,
  input  logic [NUM_FN*ADDR_W-1:0] cfg_addr_i,
  input  logic [NUM_FN*DATA_W-1:0] cfg_data_i,
  input  logic [NUM_FN-1:0]        cfg_en_i,
  input  logic [NUM_FN*MME_W-1:0]  cfg_mme_i,
  input  logic [NUM_FN*NVEC-1:0]   cfg_mask_i,
  output logic                     sel_ok_o,
  output logic                     sel_masked_o,
  output logic [ADDR_W-1:0]        sel_addr_o,
  output logic [DATA_W-1:0]        sel_data_o
);
  logic              fn_hit;
  logic              fn_en;
  logic              fn_mask_bit;
  logic [MME_W-1:0]  fn_mme;
  logic [DATA_W-1:0] fn_data;
  logic [VEC_W:0]    vec_count;
  logic [VEC_W-1:0]  vec_keep;
  logic [DATA_W-1:0] keep_ext;
  logic [DATA_W-1:0] vec_ext;

  // function mux
  always_comb begin
    fn_hit      = 1'b0;
    fn_en       = 1'b0;
    fn_mask_bit = 1'b0;
    fn_mme      = '0;
    fn_data     = '0;
    sel_addr_o  = '0;
    for (int f = 0; f < NUM_FN; f++) begin
      if (fn_i == FN_W'(f)) begin
        fn_hit      = 1'b1;
        fn_en       = cfg_en_i[f];
        fn_mask_bit = cfg_mask_i[f*NVEC + int'(vec_i)];
        fn_mme      = cfg_mme_i[f*MME_W +: MME_W];
        fn_data     = cfg_data_i[f*DATA_W +: DATA_W];
        sel_addr_o  = cfg_addr_i[f*ADDR_W +: ADDR_W];
      end
    end
  end

  // vector-count code: codes above log2(NVEC) fall back to one vector
  always_comb begin
    if (fn_mme <= MME_W'(VEC_W)) vec_count = (VEC_W+1)'(1) << fn_mme;
    else                         vec_count = (VEC_W+1)'(1);
    vec_keep = VEC_W'(vec_count - (VEC_W+1)'(1));
  end

  assign keep_ext     = DATA_W'(vec_keep);
  assign vec_ext      = DATA_W'(vec_i);
  assign sel_data_o   = (fn_data & ~keep_ext) | (vec_ext & keep_ext);
  assign sel_ok_o     = fn_hit && fn_en && ({1'b0, vec_i} < vec_count);
  assign sel_masked_o = fn_mask_bit;
endmodule

// File: rtl/msi_pend_regs.sv
module msi_pend_regs #(
  parameter int NUM_FN = 2,
  parameter int NVEC   = 32,
  parameter int FN_W   = 8,
  localparam int VEC_W = $clog2(NVEC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set_en_i,
  input  logic                   wr_en_i,
  input  logic                   wr_data_i,
  input  logic [FN_W-1:0]        fn_i,
  input  logic [VEC_W-1:0]       vec_i,
  output logic [NUM_FN*NVEC-1:0] pend_o
);
  for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
    logic            hit_set;
    logic            hit_wr;
    logic            upd_en;
    logic [NVEC-1:0] pend_d;
    logic [NVEC-1:0] pend_q;

    assign hit_set = set_en_i && (fn_i == FN_W'(f));
    assign hit_wr  = wr_en_i  && (fn_i == FN_W'(f));
    assign upd_en  = hit_set || hit_wr;

    always_comb begin
      pend_d = pend_q;
      if (hit_set)     pend_d[vec_i] = 1'b1;
      else if (hit_wr) pend_d[vec_i] = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q <= '0;
      else if (upd_en) pend_q <= pend_d;
    end

    assign pend_o[f*NVEC +: NVEC] = pend_q;
  end
endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
  import msi_req_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 16,
  parameter int TC_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [TC_W-1:0]   tc_i,
  input  logic              sel_ok_i,
  input  logic              sel_masked_i,
  input  logic [ADDR_W-1:0] sel_addr_i,
  input  logic [DATA_W-1:0] sel_data_i,
  input  logic              msg_ready_i,
  input  logic              pbw_en_i,
  output logic              ack_o,
  output logic [1:0]        status_o,
  output logic              msg_valid_o,
  output logic [ADDR_W-1:0] msg_addr_o,
  output logic [DATA_W-1:0] msg_data_o,
  output logic [TC_W-1:0]   msg_tc_o,
  output logic              pend_set_o,
  output logic              pend_wr_o,
  output logic              proto_err_o
);
  msi_fsm_e          state_q, state_d;
  msi_sts_e          sts_q, sts_d;
  logic              sts_en;
  logic              desc_en;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [TC_W-1:0]   tc_q;
  logic              err_q, err_d;

  // next state
  always_comb begin
    state_d = state_q;
    sts_d   = sts_q;
    sts_en  = 1'b0;
    desc_en = 1'b0;
    unique case (state_q)
      FSM_IDLE: if (req_i) begin
        if (!sel_ok_i) begin
          sts_d = STS_ABORT; sts_en = 1'b1; state_d = FSM_ACK;
        end else if (sel_masked_i) begin
          sts_d = STS_HELD;  sts_en = 1'b1; state_d = FSM_ACK;
        end else begin
          desc_en = 1'b1; state_d = FSM_SEND;
        end
      end
      FSM_SEND: if (msg_ready_i) begin
        sts_d = STS_SENT; sts_en = 1'b1; state_d = FSM_ACK;
      end
      FSM_ACK:  state_d = req_i ? FSM_HOLD : FSM_IDLE;
      FSM_HOLD: if (!req_i) state_d = FSM_IDLE;
      default:  state_d = FSM_IDLE;
    endcase
  end

  assign pend_set_o = (state_q == FSM_IDLE) && req_i && sel_ok_i && sel_masked_i;
  assign pend_wr_o  = pbw_en_i && !req_i;
  assign err_d      = err_q || (pbw_en_i && req_i);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FSM_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= STS_SENT;
    else if (sts_en) sts_q <= sts_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      tc_q   <= '0;
    end else if (desc_en) begin
      addr_q <= sel_addr_i;
      data_q <= sel_data_i;
      tc_q   <= tc_i;
    end
  end

  assign ack_o       = (state_q == FSM_ACK);
  assign status_o    = sts_q;
  assign msg_valid_o = (state_q == FSM_SEND);
  assign msg_addr_o  = addr_q;
  assign msg_data_o  = data_q;
  assign msg_tc_o    = tc_q;
  assign proto_err_o = err_q;
endmodule

// File: rtl/msi_req_ctrl.sv
module msi_req_ctrl #(
  parameter int NUM_FN = 2,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 16,
  parameter int NVEC   = 32,
  parameter int FN_W   = 8,
  parameter int TC_W   = 3,
  parameter int MME_W  = 3,
  localparam int VEC_W = $clog2(NVEC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_i,
  input  logic [FN_W-1:0]          req_fn_i,
  input  logic [VEC_W-1:0]         req_vec_i,
  input  logic [TC_W-1:0]          req_tc_i,
  output logic                     ack_o,
  output logic [1:0]               status_o,
  input  logic                     pbw_en_i,
  input  logic                     pbw_data_i,
  input  logic [NUM_FN*ADDR_W-1:0] cfg_addr_i,
  input  logic [NUM_FN*DATA_W-1:0] cfg_data_i,
  input  logic [NUM_FN-1:0]        cfg_en_i,
  input  logic [NUM_FN*MME_W-1:0]  cfg_mme_i,
  input  logic [NUM_FN*NVEC-1:0]   cfg_mask_i,
  output logic [NUM_FN*NVEC-1:0]   pend_o,
  output logic                     msg_valid_o,
  input  logic                     msg_ready_i,
  output logic [ADDR_W-1:0]        msg_addr_o,
  output logic [DATA_W-1:0]        msg_data_o,
  output logic [TC_W-1:0]          msg_tc_o,
  output logic                     proto_err_o
);
  logic              rst_core_n;
  logic              sel_ok;
  logic              sel_masked;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_data;
  logic              pend_set;
  logic              pend_wr;

  msi_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  msi_cfg_select #(
    .NUM_FN(NUM_FN), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .NVEC(NVEC), .FN_W(FN_W), .MME_W(MME_W)
  ) u_sel (
    .fn_i         (req_fn_i),
    .vec_i        (req_vec_i),
    .cfg_addr_i   (cfg_addr_i),
    .cfg_data_i   (cfg_data_i),
    .cfg_en_i     (cfg_en_i),
    .cfg_mme_i    (cfg_mme_i),
    .cfg_mask_i   (cfg_mask_i),
    .sel_ok_o     (sel_ok),
    .sel_masked_o (sel_masked),
    .sel_addr_o   (sel_addr),
    .sel_data_o   (sel_data)
  );

  msi_req_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TC_W(TC_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .req_i        (req_i),
    .tc_i         (req_tc_i),
    .sel_ok_i     (sel_ok),
    .sel_masked_i (sel_masked),
    .sel_addr_i   (sel_addr),
    .sel_data_i   (sel_data),
    .msg_ready_i  (msg_ready_i),
    .pbw_en_i     (pbw_en_i),
    .ack_o        (ack_o),
    .status_o     (status_o),
    .msg_valid_o  (msg_valid_o),
    .msg_addr_o   (msg_addr_o),
    .msg_data_o   (msg_data_o),
    .msg_tc_o     (msg_tc_o),
    .pend_set_o   (pend_set),
    .pend_wr_o    (pend_wr),
    .proto_err_o  (proto_err_o)
  );

  msi_pend_regs #(.NUM_FN(NUM_FN), .NVEC(NVEC), .FN_W(FN_W)) u_pend (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .set_en_i  (pend_set),
    .wr_en_i   (pend_wr),
    .wr_data_i (pbw_data_i),
    .fn_i      (req_fn_i),
    .vec_i     (req_vec_i),
    .pend_o    (pend_o)
  );
endmodule

// File: rtl/msi_req_ctrl_chk.sv
module msi_req_ctrl_chk #(
  parameter int NUM_FN = 2,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 16,
  parameter int NVEC   = 32,
  parameter int TC_W   = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_i,
  input logic                   pbw_en_i,
  input logic                   ack_o,
  input logic [1:0]             status_o,
  input logic                   msg_valid_o,
  input logic                   msg_ready_i,
  input logic [ADDR_W-1:0]      msg_addr_o,
  input logic [DATA_W-1:0]      msg_data_o,
  input logic [TC_W-1:0]        msg_tc_o,
  input logic [NUM_FN*NVEC-1:0] pend_o,
  input logic                   proto_err_o
);
  p_ack_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  p_status_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (status_o != 2'b11));

  p_desc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && !msg_ready_i) |=>
      (msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o) && $stable(msg_tc_o)));

  p_ack_after_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && msg_ready_i) |=> (ack_o && status_o == 2'b00 && !msg_valid_o));

  p_no_desc_on_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> !msg_valid_o);

  p_no_retake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && req_i) |=> (!ack_o && !msg_valid_o));

  p_pend_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_i && !pbw_en_i) |=> $stable(pend_o));

  p_clash_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && pbw_en_i) |=> proto_err_o);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |=> proto_err_o);
endmodule

bind msi_req_ctrl msi_req_ctrl_chk #(
  .NUM_FN(NUM_FN), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NVEC(NVEC), .TC_W(TC_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .req_i       (req_i),
  .pbw_en_i    (pbw_en_i),
  .ack_o       (ack_o),
  .status_o    (status_o),
  .msg_valid_o (msg_valid_o),
  .msg_ready_i (msg_ready_i),
  .msg_addr_o  (msg_addr_o),
  .msg_data_o  (msg_data_o),
  .msg_tc_o    (msg_tc_o),
  .pend_o      (pend_o),
  .proto_err_o (proto_err_o)
);

// File: tb/msi_req_ctrl_tb_top.sv
`timescale 1ns/1ps
module msi_req_ctrl_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req;
  logic [7:0]   req_fn;
  logic [4:0]   req_vec;
  logic [2:0]   req_tc;
  logic         ack_o;
  logic [1:0]   status_o;
  logic         pbw_en;
  logic         pbw_data;
  logic [127:0] cfg_addr;
  logic [31:0]  cfg_data;
  logic [1:0]   cfg_en;
  logic [5:0]   cfg_mme;
  logic [63:0]  cfg_mask;
  logic [63:0]  pend_o;
  logic         msg_valid_o;
  logic         ready;
  logic [63:0]  msg_addr_o;
  logic [15:0]  msg_data_o;
  logic [2:0]   msg_tc_o;
  logic         proto_err_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // results of the last request
  bit          r_acked, r_msg, r_stable, r_hold_ok, r_clash;
  logic [1:0]  r_status;
  logic [63:0] r_addr;
  logic [15:0] r_data;
  logic [2:0]  r_tc;

  always #2 clk = ~clk;

  msi_req_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_fn_i(req_fn), .req_vec_i(req_vec),
    .req_tc_i(req_tc), .ack_o(ack_o), .status_o(status_o), .pbw_en_i(pbw_en),
    .pbw_data_i(pbw_data), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .cfg_en_i(cfg_en), .cfg_mme_i(cfg_mme), .cfg_mask_i(cfg_mask), .pend_o(pend_o),
    .msg_valid_o(msg_valid_o), .msg_ready_i(ready), .msg_addr_o(msg_addr_o),
    .msg_data_o(msg_data_o), .msg_tc_o(msg_tc_o), .proto_err_o(proto_err_o)
  );

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic int exp_count(input logic [2:0] m);
    return (m <= 3'd5) ? (1 << m) : 1;
  endfunction

  function automatic logic [15:0] exp_data(input logic [15:0] d, input logic [4:0] v, input logic [2:0] m);
    logic [15:0] keep;
    keep = 16'(exp_count(m) - 1);
    return (d & ~keep) | (16'(v) & keep);
  endfunction

  task automatic issue(input logic [7:0] fn, input logic [4:0] vec, input logic [2:0] tc,
                       input int stall, input int keep, input bit with_pbw);
    int held;
    held = 0;
    r_acked = 0; r_msg = 0; r_stable = 1; r_hold_ok = 1; r_clash = 0;
    @(negedge clk);
    req = 1'b1; req_fn = fn; req_vec = vec; req_tc = tc; ready = 1'b0;
    if (with_pbw) begin pbw_en = 1'b1; pbw_data = 1'b1; end
    for (int i = 0; i < stall + 20 && !r_acked; i++) begin
      @(negedge clk);
      pbw_en = 1'b0;
      if (ack_o) begin
        r_acked = 1; r_status = status_o;
        if (msg_valid_o) r_clash = 1;
      end else if (msg_valid_o) begin
        if (!r_msg) begin
          r_msg = 1; r_addr = msg_addr_o; r_data = msg_data_o; r_tc = msg_tc_o;
        end else if (msg_addr_o !== r_addr || msg_data_o !== r_data || msg_tc_o !== r_tc) begin
          r_stable = 0;
        end
        if (held >= stall) ready = 1'b1;
        held++;
      end
    end
    ready = 1'b0;
    for (int k = 0; k < keep; k++) begin
      @(negedge clk);
      if (ack_o || msg_valid_o) r_hold_ok = 0;
    end
    req = 1'b0;
    @(negedge clk);
  endtask

  task automatic pwrite(input logic [7:0] fn, input logic [4:0] vec, input logic d);
    @(negedge clk);
    pbw_en = 1'b1; pbw_data = d; req_fn = fn; req_vec = vec;
    @(negedge clk);
    pbw_en = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    req = 0; req_fn = 0; req_vec = 0; req_tc = 0; pbw_en = 0; pbw_data = 0; ready = 0;
    cfg_addr = {64'h0000_0001_FEED_0040, 64'hFEE0_0000_0000_1000};
    cfg_data = {16'h1234, 16'hABC0};
    cfg_en   = 2'b11;
    cfg_mme  = {3'b101, 3'b010};
    cfg_mask = '0;
    repeat (3) @(negedge clk);
    chk("R1", "ack in reset", 64'(ack_o), 64'd0);
    chk("R1", "valid in reset", 64'(msg_valid_o), 64'd0);
    chk("R1", "pending in reset", pend_o, 64'd0);
    chk("R1", "error flag in reset", 64'(proto_err_o), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "pending after reset", pend_o, 64'd0);
  endtask

  task automatic t_send_basic;
    issue(8'd0, 5'd2, 3'd5, 0, 0, 0);
    chk("R2", "acked", 64'(r_acked), 64'd1);
    chk("R2", "status sent", 64'(r_status), 64'd0);
    chk("R5", "fn0 address", r_addr, 64'hFEE0_0000_0000_1000);
    chk("R5", "fn0 merged data", 64'(r_data), 64'(exp_data(16'hABC0, 5'd2, 3'b010)));
    chk("R5", "traffic class", 64'(r_tc), 64'd5);
    chk("R7", "valid low at ack", 64'(r_clash), 64'd0);
  endtask

  task automatic t_send_stall;
    issue(8'd1, 5'd31, 3'd3, 4, 0, 0);
    chk("R7", "status after stall", 64'(r_status), 64'd0);
    chk("R7", "descriptor stable while stalled", 64'(r_stable), 64'd1);
    chk("R5", "fn1 address", r_addr, 64'h0000_0001_FEED_0040);
    chk("R5", "fn1 merged data", 64'(r_data), 64'h123F);
  endtask

  task automatic t_code_sweep;
    cfg_data[15:0] = 16'h5A5A;
    for (int m = 0; m < 8; m++) begin
      int c;
      cfg_mme[2:0] = 3'(m);
      c = exp_count(3'(m));
      issue(8'd0, 5'(c - 1), 3'(m), 0, 0, 0);
      chk("R4", $sformatf("code %0d top vector status", m), 64'(r_status), 64'd0);
      chk("R5", $sformatf("code %0d data", m), 64'(r_data), 64'(exp_data(16'h5A5A, 5'(c - 1), 3'(m))));
      if (c < 32) begin
        issue(8'd0, 5'(c), 3'(m), 0, 0, 0);
        chk("R4", $sformatf("code %0d vector past count", m), 64'(r_status), 64'd2);
        chk("R3", $sformatf("code %0d no descriptor", m), 64'(r_msg), 64'd0);
      end
    end
    cfg_mme[2:0] = 3'b010;
  endtask

  task automatic t_abort;
    logic [63:0] snap;
    cfg_mask = '1;
    snap = pend_o;
    issue(8'd2, 5'd0, 3'd0, 0, 0, 0);
    chk("R3", "bad function status", 64'(r_status), 64'd2);
    chk("R3", "bad function no descriptor", 64'(r_msg), 64'd0);
    cfg_en[1] = 1'b0;
    issue(8'd1, 5'd4, 3'd0, 0, 0, 0);
    chk("R3", "disabled function status", 64'(r_status), 64'd2);
    chk("R3", "no pending change on abort", pend_o, snap);
    cfg_en[1] = 1'b1;
    cfg_mask = '0;
  endtask

  task automatic t_masked;
    cfg_mask = 64'd1 << 41;
    issue(8'd1, 5'd9, 3'd1, 0, 0, 0);
    chk("R6", "masked status", 64'(r_status), 64'd1);
    chk("R6", "masked no descriptor", 64'(r_msg), 64'd0);
    chk("R6", "pending bit 41", pend_o, 64'd1 << 41);
    cfg_mask = '0;
  endtask

  task automatic t_pend_write;
    pwrite(8'd1, 5'd9, 1'b0);
    chk("R9", "clear bit 41", pend_o, 64'd0);
    pwrite(8'd0, 5'd3, 1'b1);
    chk("R9", "set bit 3", pend_o, 64'd8);
    pwrite(8'd5, 5'd3, 1'b0);
    chk("R9", "out-of-range function ignored", pend_o, 64'd8);
    pwrite(8'd0, 5'd3, 1'b0);
    chk("R9", "clear bit 3", pend_o, 64'd0);
  endtask

  task automatic t_clash;
    cfg_en[0] = 1'b0;
    issue(8'd0, 5'd7, 3'd0, 0, 0, 1);
    chk("R10", "request still answered", 64'(r_status), 64'd2);
    chk("R10", "write ignored", pend_o, 64'd0);
    chk("R10", "error flag raised", 64'(proto_err_o), 64'd1);
    cfg_en[0] = 1'b1;
    issue(8'd0, 5'd1, 3'd0, 0, 0, 0);
    chk("R10", "error flag sticky", 64'(proto_err_o), 64'd1);
  endtask

  task automatic t_hold;
    issue(8'd0, 5'd1, 3'd2, 0, 3, 0);
    chk("R8", "first ack", 64'(r_status), 64'd0);
    chk("R8", "no retake while held high", 64'(r_hold_ok), 64'd1);
    issue(8'd0, 5'd2, 3'd2, 0, 0, 0);
    chk("R8", "accepted after drop", 64'(r_status), 64'd0);
  endtask

  initial begin
    t_reset();
    t_send_basic();
    t_send_stall();
    t_code_sweep();
    t_abort();
    t_masked();
    t_pend_write();
    t_hold();
    t_clash();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400us;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule